// File: doc/BRIEF.md
# Multi-Depth Luma Pixel Serializer

The serializer takes one 16-bit brightness word for each host bus cycle and plays it out as a stream of 4-bit luma codes. These codes are meant to be added on top of an existing video picture. A 2-bit mode input chooses how the word is cut into pixels. The choices are four 4-bit pixels, eight 2-bit pixels or sixteen 1-bit pixels, or the output can be switched off. Pixel width scales with depth, so every word covers the same stretch of the scan line in all three modes. As a result the line carries 160, 320 or 640 pixels at 16, 4 or 2 brightness levels. Pixels narrower than four bits are widened to the 4-bit code by repeating their bits. Full white is therefore always 1111 and black is always 0000.

The block runs on a tick clock. Each word occupies sixteen ticks, and one tick is the width of the narrowest pixel. A load strobe captures a word into a holding slot. The word moves into the playout register at the next word boundary, or right away if nothing is playing. A second strobe that arrives before that boundary overwrites the held word. The word currently playing is never cut short. The luma output is registered.

Top module: `luma_serializer`

## Requirements
- R1: While reset is asserted and after its release, before any load, `luma` is 0000 and `luma_vld` is 0.
- R2: Mode value 00 turns the output off: `luma` is 0000 and `luma_vld` is 0 in every tick, while words keep being consumed.
- R3: Mode 01 plays four 4-bit pixels, most significant nibble first. Each pixel lasts 4 ticks, and its code equals the nibble.
- R4: Mode 10 plays eight 2-bit pixels from the most significant pair down. Each pixel lasts 2 ticks, and a pair value v is sent as the code {v,v}.
- R5: Mode 11 plays sixteen 1-bit pixels from bit 15 down. Each pixel lasts 1 tick and is sent as 0000 for a 0 bit and 1111 for a 1 bit.
- R6: With `disp_en` low, `luma` is 0000 and `luma_vld` is 0. The word timing continues unchanged.
- R7: A strobe sampled at clock edge L into an idle block puts pixel tick 0 on the output after edge L+2. Tick j appears after edge L+2+j. Strobes every 16 ticks give gap-free output.
- R8: A strobe arriving while a word is playing and another is held replaces the held word. The playing word finishes all 16 ticks, and then the newest word follows with no partial pixels.
- R9: When a word ends and no word is held, `luma_vld` drops to 0 and `luma` to 0000 on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, sixteen ticks per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-tick strobe that captures `word` |
| word | input | 16 | Brightness word, bit 15 shown first |
| mode | input | 2 | 00 off, 01 16 levels, 10 4 levels, 11 2 levels |
| disp_en | input | 1 | Display enable; low forces blank output |
| luma | output | 4 | Luma code for the current tick |
| luma_vld | output | 1 | High when `luma` carries a displayed pixel |

## Verification
The case that is hardest to reach from the ports is a word that gets overwritten while it is held. To do that, a strobe has to arrive in the middle of a word, and a second strobe has to follow before that same word ends. The stimulus first loads a word from idle. It then fires two more strobes at ticks 5 and 10 of that word. It checks that the first word plays out in full and is followed directly by the third word. The second word must never be seen. The depth modes are covered by sweeping every mode and enable setting against a long run of back-to-back words. Expected codes are worked out by arithmetic on the word and the tick index.

// File: rtl/luma_ser_pkg.sv
package luma_ser_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_D4  = 2'b01,
    MODE_D2  = 2'b10,
    MODE_D1  = 2'b11
  } disp_mode_e;

  // Number of pixel depths the serializer can produce (4, 2 and 1 bit).
  localparam int unsigned NUM_DEPTHS = 3;

endpackage

// File: rtl/lps_rst_sync.sv
module lps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/lps_word_stage.sv
// Holding slot plus playout register. A word waits in the holding slot
// until the current word ends, then moves across whole.
module lps_word_stage #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              active,
  output logic [WORD_W-1:0] play,
  output logic [CNT_W-1:0]  tick
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic              held_q, held_d;
  logic [WORD_W-1:0] play_q, play_d;
  logic [CNT_W-1:0]  tick_q, tick_d;
  logic              act_q, act_d;
  logic              boundary;
  logic              hold_en, play_en;

  always_comb begin
    boundary = !act_q || (tick_q == LAST_TICK);
    hold_en  = load;
    hold_d   = word;
    play_en  = boundary && held_q;
    play_d   = hold_q;

    // Holding slot flag: a strobe always wins, otherwise a boundary drains it.
    if (load)          held_d = 1'b1;
    else if (boundary) held_d = 1'b0;
    else               held_d = held_q;

    // Tick counter and activity.
    if (boundary) begin
      tick_d = '0;
      act_d  = held_q;
    end else begin
      tick_d = tick_q + 1'b1;
      act_d  = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      held_q <= 1'b0;
      play_q <= '0;
      tick_q <= '0;
      act_q  <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (play_en) play_q <= play_d;
      held_q <= held_d;
      tick_q <= tick_d;
      act_q  <= act_d;
    end
  end

  assign active = act_q;
  assign play   = play_q;
  assign tick   = tick_q;

endmodule

// File: rtl/lps_pixel_pick.sv
// Picks the pixel under the current tick for each depth and widens it by
// bit replication; the mode then selects one lane.
module lps_pixel_pick
  import luma_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LUMA_W = 4,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] play,
  input  logic [CNT_W-1:0]  tick,
  input  disp_mode_e        mode,
  input  logic              show,
  output logic [LUMA_W-1:0] luma_d,
  output logic              vld_d
);

  logic [LUMA_W-1:0] lane_code [NUM_DEPTHS];

  for (genvar k = 0; k < NUM_DEPTHS; k++) begin : g_lane
    localparam int unsigned BITS = LUMA_W >> k;
    localparam int unsigned LB   = $clog2(BITS);
    localparam logic [CNT_W-1:0] BASE_MASK = ~CNT_W'((1 << LB) - 1);

    logic [CNT_W-1:0]  base;
    logic [WORD_W-1:0] aligned;

    // A pixel of BITS bits lasts BITS ticks: the first tick of the pixel is
    // also the bit offset of its most significant bit.
    assign base    = tick & BASE_MASK;
    assign aligned = play << base;
    assign lane_code[k] = {(LUMA_W / BITS){aligned[WORD_W-1 -: BITS]}};
  end

  always_comb begin
    case (mode)
      MODE_D4: luma_d = lane_code[0];
      MODE_D2: luma_d = lane_code[1];
      MODE_D1: luma_d = lane_code[2];
      default: luma_d = '0;
    endcase
    vld_d = show && (mode != MODE_OFF);
    if (!vld_d) luma_d = '0;
  end

endmodule

// File: rtl/lps_out_reg.sv
module lps_out_reg #(
  parameter int unsigned LUMA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LUMA_W-1:0] luma_d,
  input  logic              vld_d,
  output logic [LUMA_W-1:0] luma_q,
  output logic              vld_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      luma_q <= luma_d;
      vld_q  <= vld_d;
    end
  end

endmodule

// File: rtl/luma_serializer.sv
module luma_serializer
  import luma_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LUMA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        mode,
  input  logic              disp_en,
  output logic [LUMA_W-1:0] luma,
  output logic              luma_vld
);

  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              rst_n_sync;
  logic              active;
  logic [WORD_W-1:0] play;
  logic [CNT_W-1:0]  tick;
  disp_mode_e        mode_e;
  logic [LUMA_W-1:0] luma_d;
  logic              vld_d;

  assign mode_e = disp_mode_e'(mode);

  lps_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lps_word_stage #(.WORD_W(WORD_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load   (load),
    .word   (word),
    .active (active),
    .play   (play),
    .tick   (tick)
  );

  lps_pixel_pick #(.WORD_W(WORD_W), .LUMA_W(LUMA_W)) u_pick (
    .play   (play),
    .tick   (tick),
    .mode   (mode_e),
    .show   (active && disp_en),
    .luma_d (luma_d),
    .vld_d  (vld_d)
  );

  lps_out_reg #(.LUMA_W(LUMA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .luma_d (luma_d),
    .vld_d  (vld_d),
    .luma_q (luma),
    .vld_q  (luma_vld)
  );

endmodule

// File: rtl/luma_serializer_chk.sv
module luma_serializer_chk #(
  parameter int unsigned LUMA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              disp_en,
  input logic [LUMA_W-1:0] luma,
  input logic              luma_vld
);

  // R2: off mode leaves nothing visible on the next tick
  assert_off_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (!luma_vld && luma == '0));

  // R6: enable low blanks the next tick
  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (!luma_vld && luma == '0));

  // R9: an invalid tick always carries black
  assert_idle_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !luma_vld |-> (luma == '0));

  // R5: two-level mode only emits the extreme codes
  assert_mono_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (luma == '0 || luma == '1));

  // R4: four-level mode repeats its pair in both halves of the code
  assert_pair_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (luma[LUMA_W-1 -: LUMA_W/2] == luma[LUMA_W/2-1:0]));

endmodule

bind luma_serializer luma_serializer_chk #(.LUMA_W(LUMA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .disp_en  (disp_en),
  .luma     (luma),
  .luma_vld (luma_vld)
);

// File: tb/luma_serializer_tb_top.sv
module luma_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 24;

  logic        clk;
  logic        rst_n;
  logic        load;
  logic [15:0] word;
  logic [1:0]  mode;
  logic        disp_en;
  logic [3:0]  luma;
  logic        luma_vld;

  int n_chk  = 0;
  int n_fail = 0;

  luma_serializer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word     (word),
    .mode     (mode),
    .disp_en  (disp_en),
    .luma     (luma),
    .luma_vld (luma_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] gen_word(input int i, input int seed);
    if (i == 0) return 16'hFFFF;
    if (i == 1) return 16'h0000;
    return 16'((i * 40503 + seed * 7919) ^ (i << 7) ^ (seed << 3));
  endfunction

  // Expected code for tick j of word w under mode m with enable e.
  function automatic logic [3:0] exp_code(input int m, input int e,
                                          input logic [15:0] w, input int j);
    int b, p, v;
    if (m == 0 || e == 0) return 4'd0;
    b = 4 >> (m - 1);
    p = j / b;
    v = (int'(w) >> (16 - b * (p + 1))) & ((1 << b) - 1);
    if (b == 4) return 4'(v);
    if (b == 2) return 4'(v * 5);
    return 4'(v * 15);
  endfunction

  task automatic check(input string req, input logic [3:0] el, input logic ev);
    n_chk++;
    if (luma !== el || luma_vld !== ev) begin
      n_fail++;
      $display("FAIL %s: luma=%h vld=%b expected luma=%h vld=%b",
               req, luma, luma_vld, el, ev);
    end
  endtask

  // Back-to-back words, one strobe every 16 ticks (R7). Call at a negedge.
  task automatic run_stream(input int m, input int e, input int seed);
    logic [15:0] w;
    string req;
    req = (e == 0) ? "R6" : (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
    mode    = 2'(m);
    disp_en = e[0];
    for (int c = 0; c <= 16 * WORDS + 4; c++) begin
      load = (c % 16 == 0) && (c / 16 < WORDS);
      word = gen_word(c / 16, seed);
      @(negedge clk);
      if (c >= 2 && (c - 2) / 16 < WORDS) begin
        w = gen_word((c - 2) / 16, seed);
        check(req, exp_code(m, e, w, (c - 2) % 16), (m != 0) && (e != 0));
      end else if (c >= 2) begin
        check("R9", 4'd0, 1'b0);
      end
    end
    load = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] wa, wb, wc;
    rst_n   = 1'b0;
    load    = 1'b0;
    word    = '0;
    mode    = 2'b11;
    disp_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 4'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 4'd0, 1'b0);

    // Sweep every mode and enable setting (R2..R7, R9).
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        run_stream(m, e, m * 2 + e + 1);

    // R8: replacement of the held word; strobes at ticks 0, 5, 10.
    wa = 16'hC3A5; wb = 16'h0F0F; wc = 16'h5A96;
    mode = 2'b10; disp_en = 1'b1;
    for (int c = 0; c <= 36; c++) begin
      load = (c == 0) || (c == 5) || (c == 10);
      word = (c == 0) ? wa : (c == 5) ? wb : wc;
      @(negedge clk);
      if (c >= 2 && c < 18)       check("R8", exp_code(2, 1, wa, c - 2), 1'b1);
      else if (c >= 18 && c < 34) check("R8", exp_code(2, 1, wc, c - 18), 1'b1);
      else if (c >= 34)           check("R9", 4'd0, 1'b0);
    end
    load = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule